// File: doc/BRIEF.md
# Ping-Pong DMA Channel Controller

This block is one DMA channel that streams data between memory and a single peripheral FIFO address. Software loads two buffer descriptors (a start address and a unit count for each), enables them, and sets the run bit. The engine then issues one transfer beat for each peripheral request. It works through the active buffer, marks that buffer done, and turns to the other buffer. Software can refill the finished buffer while the other one drains, so a stream runs without gaps.

Control goes through one mode register. One write offset sets the bits written as ones and another clears them. The done, active-buffer and halted bits belong to the engine; software can only clear the done bits. To stop, software clears the run bit and polls the halted bit before it touches the buffers. An interrupt output is high while interrupt enable is set and a buffer is marked done.

Top module: `pp_dma_channel`

## Requirements
- R1: A write to offset 0x00 ORs the written ones into the mode register's software bits, and a write to offset 0x04 clears the bits written as ones. The software bits are 0, 2, 5, 7, 8-13 and 16-23. `rd_data` returns the register selected by `reg_addr` one cycle after that address is presented. Offset 0x00 reads the mode register; offsets 0x04 and unused offsets read zero.
- R2: Offset 0x08 holds the peripheral FIFO address. Buffer 0 has its start address at 0x0C and its count at 0x10; buffer 1 has its start address at 0x14 and its count at 0x18. Each count is bits 15:0 of the write data. All of these read back at their own offsets.
- R3: A beat is accepted on a clock edge when all of these hold: run (bit 5) is 1, the active buffer (selected by bit 4) has its enable set (bit 0 for buffer 0, bit 2 for buffer 1), its count is nonzero, and `periph_req` is high. In the next cycle `beat_valid` is high, `beat_mem_addr` is the buffer's start register as it was before the edge, `beat_periph_addr` is the FIFO address, and `beat_dir` is mode bit 12. The start register grows by 1, 2 or 4 bytes when bits 10:9 are 0, 1 or 2–3, and the count drops by one.
- R4: When the active buffer's count reaches zero, its done bit is set (bit 1 for buffer 0, bit 3 for buffer 1), its enable bit is cleared, and the active bit 4 toggles, all on the same edge.
- R5: If the newly active buffer is not enabled, no beats are issued and the run bit stays set, even with `periph_req` high.
- R6: An enabled active buffer whose count is zero completes on the next edge while run is set (as in R4) without issuing a beat.
- R7: Halted (bit 6) is 1 after reset. It becomes 1 one cycle after run is cleared and becomes 0 one cycle after run is set. `beat_valid` is never high while halted reads 1. A beat accepted on the edge that clears run is still issued.
- R8: Writes through the set port do not change bits 1, 3, 4 or 6. Writing a one to bit 1 or bit 3 through the clear port clears that done bit.
- R9: `irq` is registered: it is high one cycle after interrupt enable (bit 7) and either done bit are both set, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Byte offset for write and read |
| reg_wdata | input | 32 | Register write data |
| rd_data | output | 32 | Registered read data for `reg_addr` |
| periph_req | input | 1 | Peripheral asks for one beat |
| beat_valid | output | 1 | One beat issued this cycle |
| beat_mem_addr | output | ADDR_W | Memory byte address of the beat |
| beat_periph_addr | output | ADDR_W | Peripheral FIFO address of the beat |
| beat_dir | output | 1 | Direction bit copied from the mode register |
| irq | output | 1 | Buffer-done interrupt |

## Verification
The assertions assume that reset is applied before anything else. They also assume that the peripheral request is a level, sampled once per cycle, whose acceptance depends only on the channel's own state, so a request may be high for any length of time. The stimulus drives every input on the falling edge and holds it for a full cycle. It never writes the set and clear ports in the same cycle, and it runs the request as always low, always high, or a pseudo-random pattern. The engine therefore meets idle gaps, back-to-back beats, and a stop in the middle of a buffer.

// File: rtl/pp_dma_pkg.sv
package pp_dma_pkg;
  localparam int REG_W  = 32;
  localparam int OFS_W  = 5;

  // mode register bit positions (decoded by the engine and by software)
  localparam int B_EN0   = 0;
  localparam int B_DONE0 = 1;
  localparam int B_EN1   = 2;
  localparam int B_DONE1 = 3;
  localparam int B_ACT   = 4;
  localparam int B_RUN   = 5;
  localparam int B_HALT  = 6;
  localparam int B_IE    = 7;
  localparam int B_DW_LO = 9;
  localparam int B_DIR   = 12;

  // software-owned bits and engine-owned clearable bits
  localparam logic [REG_W-1:0] SW_MASK   = 32'h00FF_3FA5;
  localparam logic [REG_W-1:0] DONE_MASK = 32'h0000_000A;

  localparam logic [OFS_W-1:0] OFS_SET   = 5'h00;
  localparam logic [OFS_W-1:0] OFS_CLR   = 5'h04;
  localparam logic [OFS_W-1:0] OFS_FIFO  = 5'h08;

  function automatic logic [OFS_W-1:0] start_ofs(input int b);
    return (b == 0) ? 5'h0C : 5'h14;
  endfunction

  function automatic logic [OFS_W-1:0] count_ofs(input int b);
    return (b == 0) ? 5'h10 : 5'h18;
  endfunction

  function automatic logic [2:0] unit_bytes(input logic [1:0] dw);
    case (dw)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/pp_dma_desc.sv
module pp_dma_desc
  import pp_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_start,
  input  logic              wr_count,
  input  logic [REG_W-1:0]  wdata,
  input  logic              step,
  input  logic [2:0]        step_bytes,
  output logic [ADDR_W-1:0] start_q,
  output logic [CNT_W-1:0]  count_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      count_q <= '0;
    end else begin
      if (wr_start)
        start_q <= wdata[ADDR_W-1:0];
      else if (step)
        start_q <= start_q + ADDR_W'(step_bytes);
      if (wr_count)
        count_q <= wdata[CNT_W-1:0];
      else if (step)
        count_q <= count_q - CNT_W'(1);
    end
  end

  // R3: an exhausted count never wraps through the engine
  p_count_floor_r3: assert property (@(posedge clk) disable iff (rst)
    (count_q == '0 && !wr_count) |=> count_q == '0);
endmodule

// File: rtl/pp_dma_mode.sv
module pp_dma_mode
  import pp_dma_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             set_we,
  input  logic             clr_we,
  input  logic [REG_W-1:0] wdata,
  input  logic             finish,
  output logic [REG_W-1:0] mode_o
);
  logic [REG_W-1:0] sw_q, sw_n;
  logic [1:0]       done_q, done_n;
  logic             act_q, halt_q;

  always_comb begin
    sw_n   = sw_q;
    done_n = done_q;
    if (set_we)
      sw_n = sw_n | (wdata & SW_MASK);
    if (clr_we) begin
      sw_n   = sw_n & ~(wdata & SW_MASK);
      done_n = done_n & ~{wdata[B_DONE1], wdata[B_DONE0]};
    end
    if (finish) begin
      done_n[act_q] = 1'b1;
      if (act_q) sw_n[B_EN1] = 1'b0;
      else       sw_n[B_EN0] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_q   <= '0;
      done_q <= '0;
      act_q  <= 1'b0;
      halt_q <= 1'b1;
    end else begin
      sw_q   <= sw_n;
      done_q <= done_n;
      if (finish) act_q <= ~act_q;
      halt_q <= ~sw_q[B_RUN];
    end
  end

  always_comb begin
    mode_o          = sw_q;
    mode_o[B_DONE0] = done_q[0];
    mode_o[B_DONE1] = done_q[1];
    mode_o[B_ACT]   = act_q;
    mode_o[B_HALT]  = halt_q;
  end

  // R7: halted follows the run bit one cycle later, in both directions
  p_halt_on_stop_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(sw_q[B_RUN]) |=> halt_q);
  p_halt_drop_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(sw_q[B_RUN]) |=> !halt_q);
  // R4: buffer 0 is marked done only when it was the active one, and the engine leaves it
  p_done_switch_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q[0]) |-> ($past(!act_q) && act_q));
endmodule

// File: rtl/pp_dma_engine.sv
module pp_dma_engine
  import pp_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [REG_W-1:0]      mode_i,
  input  logic [1:0][ADDR_W-1:0] start_i,
  input  logic [1:0][CNT_W-1:0] count_i,
  input  logic [ADDR_W-1:0]     fifo_i,
  input  logic                  periph_req,
  output logic [1:0]            step_o,
  output logic [2:0]            step_bytes_o,
  output logic                  finish_o,
  output logic                  beat_valid,
  output logic [ADDR_W-1:0]     beat_mem_addr,
  output logic [ADDR_W-1:0]     beat_periph_addr,
  output logic                  beat_dir
);
  logic             act, run, en_act, fire, empty;
  logic [CNT_W-1:0] cnt_act;

  always_comb begin
    act          = mode_i[B_ACT];
    run          = mode_i[B_RUN];
    en_act       = act ? mode_i[B_EN1] : mode_i[B_EN0];
    cnt_act      = count_i[act];
    empty        = (cnt_act == '0);
    fire         = run && en_act && !empty && periph_req;
    finish_o     = run && en_act && (empty || (fire && cnt_act == CNT_W'(1)));
    step_o       = {fire && act, fire && !act};
    step_bytes_o = unit_bytes(mode_i[B_DW_LO +: 2]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_valid       <= 1'b0;
      beat_mem_addr    <= '0;
      beat_periph_addr <= '0;
      beat_dir         <= 1'b0;
    end else begin
      beat_valid <= fire;
      if (fire) begin
        beat_mem_addr    <= start_i[act];
        beat_periph_addr <= fifo_i;
        beat_dir         <= mode_i[B_DIR];
      end
    end
  end

  // R3: at most one buffer steps per cycle
  p_one_step_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(step_o));
endmodule

// File: rtl/pp_dma_channel.sv
module pp_dma_channel
  import pp_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [4:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       rd_data,
  input  logic              periph_req,
  output logic              beat_valid,
  output logic [ADDR_W-1:0] beat_mem_addr,
  output logic [ADDR_W-1:0] beat_periph_addr,
  output logic              beat_dir,
  output logic              irq
);
  localparam int NBUF = 2;

  logic [REG_W-1:0]           mode;
  logic [ADDR_W-1:0]          fifo_q;
  logic [NBUF-1:0][ADDR_W-1:0] start;
  logic [NBUF-1:0][CNT_W-1:0] count;
  logic [NBUF-1:0]            step;
  logic [2:0]                 step_bytes;
  logic                       finish;

  pp_dma_mode u_mode (
    .clk    (clk),
    .rst    (rst),
    .set_we (reg_we && reg_addr == OFS_SET),
    .clr_we (reg_we && reg_addr == OFS_CLR),
    .wdata  (reg_wdata),
    .finish (finish),
    .mode_o (mode)
  );

  for (genvar b = 0; b < NBUF; b++) begin : g_buf
    pp_dma_desc #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_desc (
      .clk        (clk),
      .rst        (rst),
      .wr_start   (reg_we && reg_addr == start_ofs(b)),
      .wr_count   (reg_we && reg_addr == count_ofs(b)),
      .wdata      (reg_wdata),
      .step       (step[b]),
      .step_bytes (step_bytes),
      .start_q    (start[b]),
      .count_q    (count[b])
    );
  end

  pp_dma_engine #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_eng (
    .clk              (clk),
    .rst              (rst),
    .mode_i           (mode),
    .start_i          (start),
    .count_i          (count),
    .fifo_i           (fifo_q),
    .periph_req       (periph_req),
    .step_o           (step),
    .step_bytes_o     (step_bytes),
    .finish_o         (finish),
    .beat_valid       (beat_valid),
    .beat_mem_addr    (beat_mem_addr),
    .beat_periph_addr (beat_periph_addr),
    .beat_dir         (beat_dir)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fifo_q  <= '0;
      rd_data <= '0;
      irq     <= 1'b0;
    end else begin
      if (reg_we && reg_addr == OFS_FIFO)
        fifo_q <= reg_wdata[ADDR_W-1:0];
      irq <= mode[B_IE] && (mode[B_DONE0] || mode[B_DONE1]);
      case (reg_addr)
        OFS_SET:      rd_data <= mode;
        OFS_FIFO:     rd_data <= 32'(fifo_q);
        start_ofs(0): rd_data <= 32'(start[0]);
        count_ofs(0): rd_data <= 32'(count[0]);
        start_ofs(1): rd_data <= 32'(start[1]);
        count_ofs(1): rd_data <= 32'(count[1]);
        default:      rd_data <= '0;
      endcase
    end
  end

  // R7: no beat leaves the channel while it reports halted
  p_quiet_halted_r7: assert property (@(posedge clk) disable iff (rst)
    mode[B_HALT] |-> !beat_valid);
  // R9: the interrupt only rises after a done bit was present
  p_irq_cause_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(mode[B_DONE0] || mode[B_DONE1]));
endmodule

// File: tb/sim_pp_dma_channel.sv
`timescale 1ns/1ps
module sim_pp_dma_channel;
  logic        clk = 0;
  logic        rst = 1;
  logic        reg_we = 0;
  logic [4:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic        periph_req = 0;
  logic [31:0] rd_data, beat_mem_addr, beat_periph_addr;
  logic        beat_valid, beat_dir, irq;

  always #4 clk = ~clk;

  pp_dma_channel u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .rd_data(rd_data), .periph_req(periph_req),
    .beat_valid(beat_valid), .beat_mem_addr(beat_mem_addr),
    .beat_periph_addr(beat_periph_addr), .beat_dir(beat_dir), .irq(irq)
  );

  int total = 0, bad = 0, nbeats = 0, cyc = 0;
  int req_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit started = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int unsigned m_sw, m_paddr, m_rdata, m_bma, m_bpa;
  int unsigned m_start[2];
  int          m_cnt[2];
  int          m_act, m_halt, m_done0, m_done1, m_bv, m_bdir, m_irq;

  function automatic int unsigned m_mode();
    return m_sw | (m_done0 << 1) | (m_done1 << 3) | (m_act << 4) | (m_halt << 6);
  endfunction

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      m_sw = 0; m_paddr = 0; m_rdata = 0; m_bma = 0; m_bpa = 0;
      m_start[0] = 0; m_start[1] = 0; m_cnt[0] = 0; m_cnt[1] = 0;
      m_act = 0; m_halt = 1; m_done0 = 0; m_done1 = 0;
      m_bv = 0; m_bdir = 0; m_irq = 0;
    end else begin
      int run, en, c, nb, fire, fin, old_run, dw;
      int unsigned md;
      md = m_mode();
      case (reg_addr)
        5'h00: m_rdata = md;
        5'h08: m_rdata = m_paddr;
        5'h0C: m_rdata = m_start[0];
        5'h10: m_rdata = m_cnt[0];
        5'h14: m_rdata = m_start[1];
        5'h18: m_rdata = m_cnt[1];
        default: m_rdata = 0;
      endcase
      run = (m_sw >> 5) & 1;
      old_run = run;
      en  = m_act ? (m_sw >> 2) & 1 : m_sw & 1;
      c   = m_cnt[m_act];
      dw  = (m_sw >> 9) & 3;
      nb  = (dw == 0) ? 1 : (dw == 1) ? 2 : 4;
      fire = (run && en && c != 0 && periph_req) ? 1 : 0;
      fin  = (run && en && (c == 0 || (fire && c == 1))) ? 1 : 0;
      m_irq = (((m_sw >> 7) & 1) && (m_done0 || m_done1)) ? 1 : 0;
      m_bv = fire;
      if (fire) begin
        m_bma = m_start[m_act]; m_bpa = m_paddr; m_bdir = (m_sw >> 12) & 1;
      end
      for (int i = 0; i < 2; i++) begin
        if (reg_we && reg_addr == (i ? 5'h14 : 5'h0C)) m_start[i] = reg_wdata;
        else if (fire && m_act == i) m_start[i] = m_start[i] + nb;
        if (reg_we && reg_addr == (i ? 5'h18 : 5'h10)) m_cnt[i] = reg_wdata & 32'hFFFF;
        else if (fire && m_act == i) m_cnt[i] = m_cnt[i] - 1;
      end
      if (reg_we && reg_addr == 5'h08) m_paddr = reg_wdata;
      if (reg_we && reg_addr == 5'h00) m_sw = m_sw | (reg_wdata & 32'h00FF3FA5);
      if (reg_we && reg_addr == 5'h04) begin
        m_sw = m_sw & ~(reg_wdata & 32'h00FF3FA5);
        if (reg_wdata[1]) m_done0 = 0;
        if (reg_wdata[3]) m_done1 = 0;
      end
      if (fin) begin
        if (m_act) begin m_done1 = 1; m_sw = m_sw & ~32'h4; end
        else       begin m_done0 = 1; m_sw = m_sw & ~32'h1; end
        m_act = 1 - m_act;
      end
      m_halt = old_run ? 0 : 1;
    end
  end

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (started) begin
      chk(rd_data == m_rdata, "R1 rd_data", rd_data, m_rdata);
      chk(beat_valid == m_bv[0], "R3 beat_valid", beat_valid, m_bv);
      if (m_bv != 0) begin
        chk(beat_mem_addr == m_bma, "R3 beat_mem_addr", beat_mem_addr, m_bma);
        chk(beat_periph_addr == m_bpa, "R3 beat_periph_addr", beat_periph_addr, m_bpa);
        chk(beat_dir == m_bdir[0], "R3 beat_dir", beat_dir, m_bdir);
      end
      chk(irq == m_irq[0], "R9 irq", irq, m_irq);
      if (beat_valid) nbeats++;
    end
    if (cyc > 20000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // request driver
  initial begin
    forever begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      periph_req = (req_mode == 1) ? 1'b1 : (req_mode == 2) ? lfsr[0] : 1'b0;
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0; reg_addr = 0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] mask,
                    input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    chk((rd_data & mask) == exp, tag, rd_data & mask, exp);
    reg_addr = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int b0;
    idle(3);
    rst = 0;
    rd(5'h00, 32'hFFFF_FFFF, 32'h0000_0040, "R7 reset halted");
    chk(irq == 0, "R9 irq after reset", irq, 0);

    // descriptors and FIFO address
    wr(5'h08, 32'h1000_0040);
    wr(5'h0C, 32'h2000_0000);
    wr(5'h10, 32'hABCD_0003);
    wr(5'h14, 32'h3000_0000);
    wr(5'h18, 32'h0000_0002);
    rd(5'h08, 32'hFFFF_FFFF, 32'h1000_0040, "R2 fifo addr");
    rd(5'h10, 32'hFFFF_FFFF, 32'h0000_0003, "R2 count0 low 16 bits");
    rd(5'h14, 32'hFFFF_FFFF, 32'h3000_0000, "R2 start1");
    rd(5'h04, 32'hFFFF_FFFF, 32'h0, "R1 clear offset reads zero");

    // set port: engine-owned bits must not take
    wr(5'h00, 32'h0000_12DF);
    rd(5'h00, 32'hFFFF_FFFF, 32'h0000_12C5, "R8 set port ignores done/act/halt");

    // run both buffers back to back
    b0 = nbeats;
    req_mode = 1;
    wr(5'h00, 32'h0000_0020);
    idle(12);
    chk(nbeats - b0 == 5, "R3 beats for counts 3+2", nbeats - b0, 5);
    rd(5'h00, 32'hFFFF_FFFF, 32'h0000_12AA, "R4 both done, enables cleared");
    rd(5'h0C, 32'hFFFF_FFFF, 32'h2000_0006, "R3 start0 advanced by 2 per beat");
    b0 = nbeats;
    idle(10);
    chk(nbeats == b0, "R5 no beats with other buffer disabled", nbeats, b0);
    chk(irq == 1, "R9 irq with done set", irq, 1);

    // clear done bits
    wr(5'h04, 32'h0000_0002);
    idle(2);
    chk(irq == 1, "R9 irq held by done1", irq, 1);
    wr(5'h04, 32'h0000_0008);
    idle(2);
    chk(irq == 0, "R9 irq low after clears", irq, 0);
    rd(5'h00, 32'hFFFF_FFFF, 32'h0000_12A0, "R8 clear port drops done bits");

    // zero-count buffer
    b0 = nbeats;
    wr(5'h00, 32'h0000_0001);
    idle(3);
    chk(nbeats == b0, "R6 zero count issues no beat", nbeats, b0);
    rd(5'h00, 32'h0000_001F, 32'h0000_0012, "R6 zero count completes");

    // 32-bit width, random requests, stop mid-buffer
    wr(5'h14, 32'h3000_0100);
    wr(5'h18, 32'h0000_0014);
    wr(5'h04, 32'h0000_0200);
    wr(5'h00, 32'h0000_0404);
    req_mode = 2;
    idle(12);
    wr(5'h04, 32'h0000_0020);
    idle(2);
    rd(5'h00, 32'h0000_0060, 32'h0000_0040, "R7 halted after stop");
    b0 = nbeats;
    idle(8);
    chk(nbeats == b0, "R7 no beats while halted", nbeats, b0);
    wr(5'h00, 32'h0000_0020);
    idle(1);
    rd(5'h00, 32'h0000_0060, 32'h0000_0020, "R7 halted drops after run");
    idle(80);
    rd(5'h00, 32'h0000_001C, 32'h0000_0008, "R4 buffer1 finished at 32-bit width");
    rd(5'h14, 32'hFFFF_FFFF, 32'h3000_0150, "R3 start1 advanced by 4 per beat");
    req_mode = 0;
    idle(4);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule